// File: doc/BRIEF.md
# Transmit FIFO Host Write Port

This block is the host-side write path into a byte-wide transmit FIFO that feeds a MAC. The host makes one access per strobe on a 16-bit data bus. Two byte enables choose between a full word and a single byte from either half of the bus. For word writes, a swap configuration bit sets which half of the word enters the FIFO first. The host flags the final access of each frame, and the block tags the last byte stored by that access as end-of-frame. The MAC side pops one byte at a time and sees the byte, its end-of-frame tag and a valid flag.

A transfer request tells the host that plenty of room remains. The host may keep writing after the request falls. Each access is either acknowledged or refused. A write is refused when the FIFO lacks room for all of its bytes, when it enables no byte lane, or when it is a read. Only an accepted write raises the data-transfer-valid acknowledge, and it does so for exactly one cycle.

A three-state controller runs the host side. In IDLE it samples the strobe. A strobed write that is accepted moves IDLE to ACK. Any other strobe moves IDLE to DENY. Both ACK and DENY go back to IDLE after one cycle, so the port takes at most one access every two cycles. Without a strobe, IDLE stays in IDLE.

Top module: `txf_host_port`

## Requirements
- R1: After reset the FIFO is empty: mac_valid=0, host_dtv=0 and tx_req=1.
- R2: A word write (host_be=2'b11) stores two bytes. With cfg_swap=0 the order is host_wdata[7:0] then host_wdata[15:8]. With cfg_swap=1 it is host_wdata[15:8] then host_wdata[7:0].
- R3: host_be=2'b01 stores the single byte host_wdata[7:0]. host_be=2'b10 stores the single byte host_wdata[15:8]. cfg_swap has no effect on single-byte writes.
- R4: An accepted write drives host_dtv high in the cycle after its strobe, and for that one cycle only.
- R5: The block stores nothing and gives no host_dtv for any of these accesses: a read (host_we=0), a write with host_be=2'b00, a word write with fewer than 2 free bytes, or a byte write with no free byte.
- R6: tx_req is high exactly when the number of free bytes is at least REQ_FREE (default 16). Writes are still accepted while tx_req is low, as long as their bytes fit.
- R7: host_last=1 on an accepted write sets the end-of-frame tag on the last byte that write stores, and on no other byte.
- R8: A strobe in the cycle right after another strobe (controller in ACK or DENY) is dropped: nothing is stored and no host_dtv follows.
- R9: mac_pop with mac_valid=1 removes the head byte. Bytes leave in the order they were stored. mac_pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_wdata | input | 16 | Write data |
| host_last | input | 1 | Marks the access as the end of a frame |
| cfg_swap | input | 1 | Word byte order: 1 = upper byte first |
| host_dtv | output | 1 | Acknowledge of an accepted write |
| tx_req | output | 1 | Transfer request, free bytes >= REQ_FREE |
| mac_pop | input | 1 | MAC removes the head byte |
| mac_valid | output | 1 | FIFO holds at least one byte |
| mac_data | output | 8 | Head byte |
| mac_eof | output | 1 | End-of-frame tag of the head byte |

## Verification
Assertions check several properties on every cycle: the acknowledge is a single-cycle pulse, reads and strobes that arrive while the controller is busy never produce an acknowledge, the occupancy never exceeds the depth, and a pop on an empty FIFO with no push leaves it empty. Some behaviour can only be shown by the bench's reference model, compared on every clock. This covers byte ordering under swap and lane selection, the placement of the end-of-frame tag, the exact cycle at which the request falls while writes continue, and the refusal of a word write when only one byte is free.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } txf_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_DENY = 2'd2
    } txf_state_t;
endpackage

// File: rtl/txf_lane_steer.sv
module txf_lane_steer
    import txf_pkg::*;
(
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    input  logic        swap,
    input  logic        last,
    output logic [1:0]  nbytes,
    output txf_entry_t  first,
    output txf_entry_t  second
);
    logic [7:0] lo_b, hi_b;
    assign lo_b = wdata[7:0];
    assign hi_b = wdata[15:8];

    always_comb begin
        nbytes = 2'd0;
        first  = '0;
        second = '0;
        unique case (be)
            2'b11: begin
                nbytes      = 2'd2;
                first.data  = swap ? hi_b : lo_b;
                second.data = swap ? lo_b : hi_b;
                second.eof  = last;
            end
            2'b01: begin
                nbytes     = 2'd1;
                first.data = lo_b;
                first.eof  = last;
            end
            2'b10: begin
                nbytes     = 2'd1;
                first.data = hi_b;
                first.eof  = last;
            end
            default: nbytes = 2'd0;
        endcase
    end
endmodule

// File: rtl/txf_wr_ctrl.sv
module txf_wr_ctrl
    import txf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic [1:0]       need,
    input  logic [CNT_W-1:0] free,
    output logic [1:0]       push_n,
    output logic             dtv
);
    txf_state_t state, state_nx;
    logic       accept;

    assign accept = (state == ST_IDLE) && cs && we && (need != 2'd0)
                    && (free >= CNT_W'(need));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (cs) state_nx = accept ? ST_ACK : ST_DENY;
                else    state_nx = ST_IDLE;
            end
            ST_ACK:  state_nx = ST_IDLE;
            ST_DENY: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        push_n = accept ? need : 2'd0;
        dtv    = (state == ST_ACK);
    end

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtv |=> !dtv);
    // R5
    read_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs && !we) |=> !dtv);
    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cs) |=> !dtv);
endmodule

// File: rtl/txf_byte_store.sv
module txf_byte_store
    import txf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n,
    input  txf_entry_t       in0,
    input  txf_entry_t       in1,
    input  logic             pop,
    output txf_entry_t       head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    txf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_pop;

    assign do_pop = pop && (count != '0);
    assign head   = mem[rp];

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= in0;
        if (push_n == 2'd2) mem[wp + PTR_W'(1)] <= in1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + PTR_W'(push_n);
            if (do_pop) rp <= rp + PTR_W'(1);
            count <= count + CNT_W'(push_n) - CNT_W'(do_pop);
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && push_n == 2'd0) |=> (count == '0));
endmodule

// File: rtl/txf_host_port.sv
module txf_host_port
    import txf_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int REQ_FREE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs,
    input  logic        host_we,
    input  logic [1:0]  host_be,
    input  logic [15:0] host_wdata,
    input  logic        host_last,
    input  logic        cfg_swap,
    output logic        host_dtv,
    output logic        tx_req,
    input  logic        mac_pop,
    output logic        mac_valid,
    output logic [7:0]  mac_data,
    output logic        mac_eof
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       nbytes, push_n;
    txf_entry_t       ent0, ent1, head;
    logic [CNT_W-1:0] count, free;

    assign free = CNT_W'(DEPTH) - count;

    txf_lane_steer u_steer (
        .be     (host_be),
        .wdata  (host_wdata),
        .swap   (cfg_swap),
        .last   (host_last),
        .nbytes (nbytes),
        .first  (ent0),
        .second (ent1)
    );

    txf_wr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (host_cs),
        .we     (host_we),
        .need   (nbytes),
        .free   (free),
        .push_n (push_n),
        .dtv    (host_dtv)
    );

    txf_byte_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (push_n),
        .in0    (ent0),
        .in1    (ent1),
        .pop    (mac_pop),
        .head   (head),
        .count  (count)
    );

    assign tx_req    = free >= CNT_W'(REQ_FREE);
    assign mac_valid = count != '0;
    assign mac_data  = head.data;
    assign mac_eof   = head.eof;

    // R6
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |-> $past(push_n != 2'd0));
endmodule

// File: tb/txf_host_port_test.sv
module txf_host_port_test;
    localparam int PERIOD   = 10;
    localparam int DEPTH    = 32;
    localparam int REQ_FREE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_we = 1'b0, host_last = 1'b0, cfg_swap = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = '0;
    logic        mac_pop = 1'b0;
    logic        host_dtv, tx_req, mac_valid, mac_eof;
    logic [7:0]  mac_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [8:0] q[$];
    int         mst = 0;   // 0 idle, 1 acked, 2 refused

    always #(PERIOD/2) clk = ~clk;

    txf_host_port #(.DEPTH(DEPTH), .REQ_FREE(REQ_FREE)) uut (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_be(host_be), .host_wdata(host_wdata), .host_last(host_last),
        .cfg_swap(cfg_swap), .host_dtv(host_dtv), .tx_req(tx_req),
        .mac_pop(mac_pop), .mac_valid(mac_valid), .mac_data(mac_data),
        .mac_eof(mac_eof)
    );

    // reference model: behavioural queue, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            mst = 0;
        end else begin
            int  need;
            bit  acc;
            int  nxt;
            need = (host_be == 2'b11) ? 2 : (host_be == 2'b00) ? 0 : 1;
            acc  = (mst == 0) && host_cs && host_we && need > 0
                   && (DEPTH - q.size()) >= need;
            nxt  = (mst == 0 && host_cs) ? (acc ? 1 : 2) : 0;
            if (mac_pop && q.size() > 0) void'(q.pop_front());
            if (acc) begin
                if (host_be == 2'b11) begin
                    q.push_back({1'b0, cfg_swap ? host_wdata[15:8] : host_wdata[7:0]});
                    q.push_back({host_last, cfg_swap ? host_wdata[7:0] : host_wdata[15:8]});
                end else if (host_be == 2'b01) begin
                    q.push_back({host_last, host_wdata[7:0]});
                end else begin
                    q.push_back({host_last, host_wdata[15:8]});
                end
            end
            mst = nxt;
        end
    end

    task automatic check1(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check1("R4/R5/R8 dtv", {7'd0, host_dtv}, {7'd0, mst == 1});
            check1("R6 tx_req", {7'd0, tx_req}, {7'd0, (DEPTH - q.size()) >= REQ_FREE});
            check1("R9 valid", {7'd0, mac_valid}, {7'd0, q.size() > 0});
            if (q.size() > 0) begin
                check1("R2/R3 data", mac_data, q[0][7:0]);
                check1("R7 eof", {7'd0, mac_eof}, {7'd0, q[0][8]});
            end
        end
    end

    task automatic access(input logic we, input logic [1:0] be, input logic [15:0] d,
                          input logic last, input int hold);
        @(negedge clk);
        host_cs = 1'b1; host_we = we; host_be = be; host_wdata = d; host_last = last;
        repeat (hold) @(negedge clk);
        host_cs = 1'b0; host_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        mac_pop = 1'b1;
        repeat (DEPTH + 2) @(negedge clk);
        mac_pop = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check1("R1 reset valid", {7'd0, mac_valid}, 8'd0);
        check1("R1 reset req", {7'd0, tx_req}, 8'd1);
        check1("R1 reset dtv", {7'd0, host_dtv}, 8'd0);
        rst_n = 1'b1;
        // R2 word order, both swap settings; R7 tag on last byte
        cfg_swap = 1'b0; access(1'b1, 2'b11, 16'hA1B2, 1'b0, 1);
        cfg_swap = 1'b1; access(1'b1, 2'b11, 16'hC3D4, 1'b1, 1);
        // R3 byte lanes, swap ignored
        access(1'b1, 2'b01, 16'h1122, 1'b0, 1);
        cfg_swap = 1'b0; access(1'b1, 2'b10, 16'h3344, 1'b1, 1);
        // R5 read and empty enables
        access(1'b0, 2'b11, 16'h5566, 1'b0, 1);
        access(1'b1, 2'b00, 16'h7788, 1'b0, 1);
        // R8 strobe held two cycles: second dropped
        access(1'b1, 2'b01, 16'h99AA, 1'b0, 2);
        drain();
        // R9 pop on empty
        mac_pop = 1'b1; repeat (3) @(negedge clk); mac_pop = 1'b0;
        // R6 fill with words past request drop until full; R5 refusals when full
        for (int i = 0; i < DEPTH/2 + 1; i++)
            access(1'b1, 2'b11, 16'(i * 16'h0203 + 16'h0100), i == 3, 1);
        access(1'b1, 2'b01, 16'h00EE, 1'b0, 1);
        // free one byte: word refused, byte accepted (R5)
        @(negedge clk); mac_pop = 1'b1; @(negedge clk); mac_pop = 1'b0;
        access(1'b1, 2'b11, 16'hDEAD, 1'b0, 1);
        access(1'b1, 2'b10, 16'hBE00, 1'b1, 1);
        // R9 write concurrent with pops
        mac_pop = 1'b1;
        access(1'b1, 2'b11, 16'h4321, 1'b1, 1);
        drain();
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule